// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into a downstream programmable logic device over a passive serial link. A start pulse opens a load. The block holds the device's active-low configuration request low for a fixed time. It then checks that the device answers with its active-low status line. After releasing the request, it waits for the device to release status, and gives up after a timeout.

Once the device is ready, the block takes bytes from a valid/ready stream and shifts each one out, least significant bit first, on a data pin. The pin is timed against a configuration clock that the block divides down from its own clock. After the byte marked last, it samples the device's configuration-done pin. If that pin is high, it sends a fixed number of trailing clock pulses and then reports success. Any check that fails, or an external abort, ends the load with a failure pulse and leaves the device pins at rest.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset and whenever the block is idle: `dev_config_n_o` is 1, `dev_clk_o` is 0, `busy_o` is 0, `byte_ready_o` is 0, and `ok_o` and `fail_o` are 0.
- R2: A start pulse drives `dev_config_n_o` low for exactly HOLD_CYC cycles. At the end of that time the block samples `dev_status_n_i`. If it reads 1 (status not asserted), the load ends with a failure pulse and no byte is ever requested.
- R3: After `dev_config_n_o` is released, the block waits for `dev_status_n_i` to become 1. If it is still 0 after TIMEOUT_CYC cycles, the load ends with a failure pulse.
- R4: A byte is taken on a cycle where both `byte_valid_i` and `byte_ready_o` are 1. `byte_ready_o` is 1 only while the shifter is empty during the data phase, and never while `dev_config_n_o` is low. The byte taken with `byte_last_i` = 1 is the final one.
- R5: Each byte is sent as 8 bits, bit 0 first and bit 7 last. Each bit is the `dev_data_o` value at a rising edge of `dev_clk_o`.
- R6: `dev_data_o` changes only while `dev_clk_o` is low and is stable across every rising edge. Each high phase of `dev_clk_o` lasts HALF_DIV system cycles. The RTL rejects at elaboration a HALF_DIV that would push the generated clock above DCLK_MAX_HZ.
- R7: After the final byte, if `dev_done_i` is 0, the load ends with a failure pulse and no further clock edge.
- R8: After the final byte, if `dev_done_i` is 1, the block produces exactly TRAIL_CLKS further rising edges on `dev_clk_o` and then a success pulse.
- R9: `abort_i` while busy returns the block to idle on the next cycle with a failure pulse, `dev_config_n_o` at 1 and `dev_clk_o` at 0. `abort_i` while idle produces no pulse.
- R10: `ok_o` and `fail_o` are single-cycle pulses and are never high together. `busy_o` is 1 from the cycle after an accepted start up to the pulse, and is 0 in the cycle of the pulse.
- R11: A start pulse while busy is ignored. The running load goes on with a single configuration request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that opens a load |
| abort_i | input | 1 | Ends a running load with failure |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte on `byte_data_i` is valid |
| byte_last_i | input | 1 | Byte is the final one of the stream |
| byte_ready_o | output | 1 | Shifter empty, byte can be taken |
| dev_status_n_i | input | 1 | Device status, active low |
| dev_done_i | input | 1 | Device configuration done |
| dev_config_n_o | output | 1 | Configuration request to device, active low |
| dev_clk_o | output | 1 | Generated configuration clock |
| dev_data_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
Each fault in the state register or the counters shows up at the pins within a few configuration clock periods.
- A bad hold or timeout count moves the release of the request or the failure pulse by whole cycles. The bench measures both to the cycle.
- A wrong bit counter or shift direction changes how many rising edges arrive per byte, or the bits they carry. This shows before the next byte is requested.
- A wrong trailing count shows as a wrong total number of edges at the success pulse.
- A state that skips the done check or ignores abort gives the wrong kind of pulse in the very next cycle.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HOLD  = 3'd1,
      ST_WREL  = 3'd2,
      ST_FETCH = 3'd3,
      ST_SHIFT = 3'd4,
      ST_DCHK  = 3'd5,
      ST_TRAIL = 3'd6
   } ps_state_e;

endpackage

// File: rtl/ps_cfg_timer.sv
// Down-counter for the request hold and the status-release timeout.
module ps_cfg_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             en_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (en_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_halfdiv.sv
// Emits one tick every HALF_DIV cycles while run_i stays high.
module ps_cfg_halfdiv #(
   parameter int unsigned HALF_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || (cnt_q == LAST)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/ps_cfg_shifter.sv
// Byte holding register; the bit order is chosen at elaboration.
module ps_cfg_shifter
   import ps_cfg_pkg::*;
#(
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] din_i,
   input  logic              shift_i,
   output logic              bit_o
);

   logic [BYTE_W-1:0] sreg_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sreg_q <= '0;
            else if (load_i)  sreg_q <= din_i;
            else if (shift_i) sreg_q <= {1'b0, sreg_q[BYTE_W-1:1]};
         end
         assign bit_o = sreg_q[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sreg_q <= '0;
            else if (load_i)  sreg_q <= din_i;
            else if (shift_i) sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
         end
         assign bit_o = sreg_q[BYTE_W-1];
      end
   endgenerate

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
   import ps_cfg_pkg::*;
#(
   parameter int unsigned SYS_CLK_HZ  = 100_000_000,
   parameter int unsigned DCLK_MAX_HZ = 50_000_000,
   parameter int unsigned HALF_DIV    = 1,
   parameter int unsigned HOLD_CYC    = 200,
   parameter int unsigned TIMEOUT_CYC = 10_000_000,
   parameter int unsigned TRAIL_CLKS  = 12,
   parameter bit          LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [BYTE_W-1:0] byte_data_i,
   input  logic              byte_valid_i,
   input  logic              byte_last_i,
   output logic              byte_ready_o,
   input  logic              dev_status_n_i,
   input  logic              dev_done_i,
   output logic              dev_config_n_o,
   output logic              dev_clk_o,
   output logic              dev_data_o,
   output logic              busy_o,
   output logic              ok_o,
   output logic              fail_o
);

   localparam int unsigned TMR_MAX = (HOLD_CYC > TIMEOUT_CYC) ? HOLD_CYC : TIMEOUT_CYC;
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
   localparam int unsigned BIT_W   = $clog2(BYTE_W);
   localparam int unsigned TRL_W   = (TRAIL_CLKS > 1) ? $clog2(TRAIL_CLKS) : 1;
   localparam logic [TMR_W-1:0] HOLD_LD  = TMR_W'(HOLD_CYC - 1);
   localparam logic [TMR_W-1:0] TOUT_LD  = TMR_W'(TIMEOUT_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
   localparam logic [TRL_W-1:0] LAST_TRL = TRL_W'(TRAIL_CLKS - 1);

   // Elaboration checks on the parameter set (R6 clock limit)
   initial begin : p_param_chk
      assert (HALF_DIV >= 1) else $error("HALF_DIV must be at least 1");
      assert (64'(SYS_CLK_HZ) <= 64'(2) * 64'(HALF_DIV) * 64'(DCLK_MAX_HZ))
         else $error("generated configuration clock above DCLK_MAX_HZ");
      assert (HOLD_CYC >= 1 && TIMEOUT_CYC >= 1) else $error("delays must be nonzero");
      assert (TRAIL_CLKS >= 1) else $error("TRAIL_CLKS must be nonzero");
   end

   ps_state_e        state_q;
   logic             cfg_n_q, dclk_q, phase_q, last_q, ok_q, fail_q;
   logic [BIT_W-1:0] bit_q;
   logic [TRL_W-1:0] trl_q;

   logic tmr_load, tmr_en, tmr_exp;
   logic [TMR_W-1:0] tmr_val;
   logic run, tick, accept, sh_load, sh_shift, start_go, stop;

   assign stop     = abort_i && (state_q != ST_IDLE);
   assign start_go = start_i && !abort_i && (state_q == ST_IDLE);
   assign accept   = (state_q == ST_FETCH) && byte_valid_i && !abort_i;

   assign tmr_load = start_go ||
                     ((state_q == ST_HOLD) && tmr_exp && !dev_status_n_i);
   assign tmr_val  = (state_q == ST_IDLE) ? HOLD_LD : TOUT_LD;
   assign tmr_en   = (state_q == ST_HOLD) || (state_q == ST_WREL);
   assign run      = (state_q == ST_SHIFT) || (state_q == ST_TRAIL);

   assign sh_load  = accept;
   assign sh_shift = (state_q == ST_SHIFT) && tick && phase_q &&
                     (bit_q != LAST_BIT) && !abort_i;

   ps_cfg_timer #(.CNT_W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .en_i       (tmr_en),
      .expired_o  (tmr_exp)
   );

   ps_cfg_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   ps_cfg_shifter #(.LSB_FIRST(LSB_FIRST)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sh_load),
      .din_i   (byte_data_i),
      .shift_i (sh_shift),
      .bit_o   (dev_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_n_q <= 1'b1;
         dclk_q  <= 1'b0;
         phase_q <= 1'b0;
         last_q  <= 1'b0;
         bit_q   <= '0;
         trl_q   <= '0;
         ok_q    <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         ok_q   <= 1'b0;
         fail_q <= 1'b0;
         if (stop) begin
            state_q <= ST_IDLE;
            cfg_n_q <= 1'b1;
            dclk_q  <= 1'b0;
            phase_q <= 1'b0;
            fail_q  <= 1'b1;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (start_go) begin
                     state_q <= ST_HOLD;
                     cfg_n_q <= 1'b0;
                  end
               end
               ST_HOLD: begin
                  if (tmr_exp) begin
                     cfg_n_q <= 1'b1;
                     if (dev_status_n_i) begin
                        state_q <= ST_IDLE;
                        fail_q  <= 1'b1;
                     end else begin
                        state_q <= ST_WREL;
                     end
                  end
               end
               ST_WREL: begin
                  if (dev_status_n_i) begin
                     state_q <= ST_FETCH;
                  end else if (tmr_exp) begin
                     state_q <= ST_IDLE;
                     fail_q  <= 1'b1;
                  end
               end
               ST_FETCH: begin
                  if (byte_valid_i) begin
                     state_q <= ST_SHIFT;
                     last_q  <= byte_last_i;
                     bit_q   <= '0;
                     phase_q <= 1'b0;
                  end
               end
               ST_SHIFT: begin
                  if (tick) begin
                     if (!phase_q) begin
                        dclk_q  <= 1'b1;
                        phase_q <= 1'b1;
                     end else begin
                        dclk_q  <= 1'b0;
                        phase_q <= 1'b0;
                        if (bit_q == LAST_BIT) begin
                           state_q <= last_q ? ST_DCHK : ST_FETCH;
                        end else begin
                           bit_q <= bit_q + 1'b1;
                        end
                     end
                  end
               end
               ST_DCHK: begin
                  if (dev_done_i) begin
                     state_q <= ST_TRAIL;
                     trl_q   <= '0;
                     phase_q <= 1'b0;
                  end else begin
                     state_q <= ST_IDLE;
                     fail_q  <= 1'b1;
                  end
               end
               ST_TRAIL: begin
                  if (tick) begin
                     if (!phase_q) begin
                        dclk_q  <= 1'b1;
                        phase_q <= 1'b1;
                     end else begin
                        dclk_q  <= 1'b0;
                        phase_q <= 1'b0;
                        if (trl_q == LAST_TRL) begin
                           state_q <= ST_IDLE;
                           ok_q    <= 1'b1;
                        end else begin
                           trl_q <= trl_q + 1'b1;
                        end
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign dev_config_n_o = cfg_n_q;
   assign dev_clk_o      = dclk_q;
   assign busy_o         = (state_q != ST_IDLE);
   assign byte_ready_o   = (state_q == ST_FETCH);
   assign ok_o           = ok_q;
   assign fail_o         = fail_q;

endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk #(
   parameter int unsigned HOLD_CYC = 200
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic abort_i,
   input logic byte_ready_o,
   input logic dev_config_n_o,
   input logic dev_clk_o,
   input logic dev_data_o,
   input logic busy_o,
   input logic ok_o,
   input logic fail_o
);

   logic [31:0] low_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt_q <= '0;
      else if (dev_config_n_o)    low_cnt_q <= '0;
      else if (low_cnt_q != '1)   low_cnt_q <= low_cnt_q + 1'b1;
   end

   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (dev_config_n_o && !dev_clk_o && !byte_ready_o));

   assert_hold_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dev_config_n_o) && !fail_o) |-> (low_cnt_q >= HOLD_CYC));

   assert_ready_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> (busy_o && dev_config_n_o && !dev_clk_o));

   assert_data_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_clk_o) |-> $stable(dev_data_o));

   assert_data_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_data_o) |-> !dev_clk_o);

   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && busy_o) |=> (fail_o && !busy_o));

   assert_ok_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |=> !ok_o);

   assert_fail_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && fail_o));

   assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (ok_o || fail_o));

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !abort_i && !busy_o) |=> busy_o);

endmodule

bind ps_cfg_master ps_cfg_master_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_i        (start_i),
   .abort_i        (abort_i),
   .byte_ready_o   (byte_ready_o),
   .dev_config_n_o (dev_config_n_o),
   .dev_clk_o      (dev_clk_o),
   .dev_data_o     (dev_data_o),
   .busy_o         (busy_o),
   .ok_o           (ok_o),
   .fail_o         (fail_o)
);

// File: tb/test_ps_cfg_master.sv
module test_ps_cfg_master;

   localparam int HD   = 2;
   localparam int HOLD = 20;
   localparam int TOUT = 300;
   localparam int TRL  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, abort = 1'b0;
   logic [7:0] bd = '0;
   logic bv = 1'b0, bl = 1'b0;
   logic rdy;
   logic status_n = 1'b1, done = 1'b0;
   logic cfg_n, dclk, ddata, busy, ok, fail;

   always #5 clk = ~clk;

   ps_cfg_master #(
      .HALF_DIV(HD), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TOUT), .TRAIL_CLKS(TRL)
   ) i_ps_cfg_master (
      .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
      .byte_data_i(bd), .byte_valid_i(bv), .byte_last_i(bl), .byte_ready_o(rdy),
      .dev_status_n_i(status_n), .dev_done_i(done),
      .dev_config_n_o(cfg_n), .dev_clk_o(dclk), .dev_data_o(ddata),
      .busy_o(busy), .ok_o(ok), .fail_o(fail)
   );

   int checks = 0, errors = 0, cyc = 0;

   // device model settings
   bit mdl_stat_ok = 1'b1;
   int mdl_rel_dly = 0;
   int relcnt = 0;
   // observation
   logic bits [0:511];
   int nedge = 0, hiw = 0, hiw_bad = 0, nepi = 0, cfgw = 0, lastw = 0;
   int wcnt = 0, nok = 0, nfail = 0, rdy_bad = 0;
   logic prev_clk = 1'b0, prev_cfg = 1'b1;
   // feeder
   logic [7:0] tx [0:15];
   int feed_n = 0, feed_idx = 0;
   bit acc = 1'b0;

   task automatic chk(input bit cond, input string req, input longint act, input longint exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // device model and pin monitor
   always @(negedge clk) begin
      if (!cfg_n) begin
         status_n = !mdl_stat_ok;
         relcnt = 0;
      end else if (!status_n) begin
         if (relcnt >= mdl_rel_dly) status_n = 1'b1;
         else relcnt++;
      end
      if (dclk && !prev_clk) begin
         if (nedge < 512) bits[nedge] = ddata;
         nedge++;
      end
      if (dclk) hiw++;
      else if (prev_clk) begin
         if (hiw != HD) hiw_bad++;
         hiw = 0;
      end
      prev_clk = dclk;
      if (!cfg_n) begin
         if (prev_cfg) begin nepi++; cfgw = 0; end
         cfgw++;
      end else if (!prev_cfg) lastw = cfgw;
      prev_cfg = cfg_n;
      if (busy && cfg_n) wcnt++;
      if (ok) nok++;
      if (fail) nfail++;
      if (rdy && !cfg_n) rdy_bad++;
   end

   // byte source with random gaps
   always begin
      @(negedge clk);
      if (acc) feed_idx++;
      if (feed_idx < feed_n) begin
         bv = ($urandom % 4) != 0;
         bd = tx[feed_idx];
         bl = (feed_idx == feed_n - 1);
      end else begin
         bv = 1'b0;
         bl = 1'b0;
      end
      #1 acc = bv && rdy;
   end

   task automatic clear_obs(input int n);
      @(posedge clk);
      #1;
      nedge = 0; hiw_bad = 0; nepi = 0; lastw = 0; wcnt = 0;
      nok = 0; nfail = 0; rdy_bad = 0; acc = 1'b0;
      feed_idx = 0; feed_n = n;
   endtask

   task automatic do_load(input int n, input bit stat_ok, input int rel, input bit done_v,
                          input bit extra_start);
      bit sent = 1'b0;
      int guard = 0;
      for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
      mdl_stat_ok = stat_ok;
      mdl_rel_dly = rel;
      done = done_v;
      clear_obs(n);
      tick();
      start = 1'b1;
      tick();
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", busy, 1);
      while ((nok + nfail) == 0 && guard < 20000) begin
         tick();
         guard++;
         start = extra_start && !sent && (nedge >= 3);
         if (start) sent = 1'b1;
      end
      start = 1'b0;
      tick();
      chk(!ok && !fail && !busy, "R10 single pulse and idle", {ok, fail, busy}, 0);
      chk(cfg_n && !dclk, "R1 pins at rest after load", {cfg_n, dclk}, 2);
   endtask

   function automatic int bit_errs(input int n);
      int e = 0;
      for (int k = 0; k < 8 * n; k++)
         if (bits[k] !== tx[k / 8][k % 8]) e++;
      return e;
   endfunction

   task automatic check_ok_run(input int n, input string tag);
      chk(nok == 1 && nfail == 0, {tag, " R10 one ok pulse"}, nok, 1);
      chk(nedge == 8 * n + TRL, {tag, " R8 edge count"}, nedge, 8 * n + TRL);
      chk(bit_errs(n) == 0, {tag, " R5 LSB-first bits"}, bit_errs(n), 0);
      chk(lastw == HOLD, {tag, " R2 request width"}, lastw, HOLD);
      chk(hiw_bad == 0, {tag, " R6 clock high width"}, hiw_bad, 0);
      chk(rdy_bad == 0 && feed_idx == n, {tag, " R4 all bytes taken"}, feed_idx, n);
      chk(nepi == 1, {tag, " R11 single request"}, nepi, 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk(cfg_n && !dclk && !busy && !rdy && !ok && !fail, "R1 reset state",
          {cfg_n, dclk, busy, rdy, ok, fail}, 6'b100000);

      // directed: single byte, immediate release
      do_load(1, 1'b1, 0, 1'b1, 1'b0);
      check_ok_run(1, "directed1");

      // random successful loads, some with a start during the load
      for (int r = 0; r < 8; r++) begin
         int n = 1 + int'($urandom % 6);
         do_load(n, 1'b1, int'($urandom % 20), 1'b1, r[0]);
         check_ok_run(n, "random");
      end

      // status not asserted during request
      do_load(2, 1'b0, 0, 1'b1, 1'b0);
      chk(nfail == 1 && nok == 0, "R2 status missing fails", nfail, 1);
      chk(nedge == 0 && wcnt == 0 && feed_idx == 0, "R2 no byte requested", nedge, 0);
      chk(lastw == HOLD, "R2 request width on fail", lastw, HOLD);

      // status never released
      do_load(2, 1'b1, 100000, 1'b1, 1'b0);
      chk(nfail == 1 && nok == 0, "R3 timeout fails", nfail, 1);
      chk(wcnt == TOUT, "R3 timeout length", wcnt, TOUT);
      chk(nedge == 0, "R3 no clock", nedge, 0);

      // done low after last byte
      do_load(3, 1'b1, 5, 1'b0, 1'b0);
      chk(nfail == 1 && nok == 0, "R7 done low fails", nfail, 1);
      chk(nedge == 24, "R7 no trailing clocks", nedge, 24);
      chk(bit_errs(3) == 0, "R5 bits before done check", bit_errs(3), 0);
      done = 1'b1;

      // abort in the middle of shifting
      for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
      mdl_stat_ok = 1'b1; mdl_rel_dly = 2;
      clear_obs(4);
      tick(); start = 1'b1; tick(); start = 1'b0;
      for (int g = 0; g < 2000 && nedge < 5; g++) tick();
      abort = 1'b1; tick(); abort = 1'b0;
      chk(fail && !busy && cfg_n && !dclk, "R9 abort while shifting",
          {fail, busy, cfg_n, dclk}, 4'b1010);
      tick();
      chk(!fail && nfail == 1, "R10 abort pulse single", nfail, 1);
      feed_n = 0;

      // abort during the request hold
      clear_obs(0);
      tick(); start = 1'b1; tick(); start = 1'b0;
      repeat (4) tick();
      abort = 1'b1; tick(); abort = 1'b0;
      chk(fail && !busy && cfg_n, "R9 abort during hold", {fail, busy, cfg_n}, 3'b101);

      // abort while idle
      clear_obs(0);
      abort = 1'b1; tick(); abort = 1'b0;
      repeat (3) tick();
      chk(nfail == 0 && !busy, "R9 idle abort ignored", nfail, 0);

      // a final clean load after the aborts
      do_load(2, 1'b1, 3, 1'b1, 1'b0);
      check_ok_run(2, "post-abort");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule